// File: doc/BRIEF.md
# Output-Queue Emulating Flit Timestamper

This block stands in the router pipeline right after route computation. It takes the place of switch arbitration. Each flit presented on one of the request ports names the output it wants. The block answers with the cycle at which that flit would leave an ideal output-queued switch. For each output it records how far ahead of the present time the departures already promised reach. A new flit is given the first free slot after that horizon, or the next cycle when that output has nothing pending. Flits to one output are therefore served strictly in arrival order.

Several ports may ask for the same output in one cycle. They receive consecutive slots. Flits that failed a later stage, such as memory conflict resolution or channel allocation, come back with a retry flag and are placed ahead of new flits. A free-running time counter wraps through its full range. No output is ever booked more than a fixed window ahead, so any two live times can be compared modulo the counter range. A flit whose slot would fall outside the window gets no grant and must present itself again.

Top module: `flit_timestamper`

## Requirements
- R1: While rst_n is low at a clock edge, all grants and the time counter are 0 after that edge.
- R2: now_time advances by exactly 1 (modulo 2^TS_W) on every clock edge out of reset. A grant and its timestamp appear on the edge after the request, and timestamps wrap modulo 2^TS_W.
- R3: A flit requesting an output that has no pending departures is stamped with the request-cycle time plus 1.
- R4: Across cycles, an output's timestamps continue from the last one it assigned. The next stamp is the larger of request-time+1 and last-assigned+1.
- R5: New flits requesting the same output in one cycle get consecutive stamps in ascending port index order.
- R6: A request with req_retry high is ordered ahead of all new requests to the same output in that cycle. Retries among themselves are ordered by ascending port index.
- R7: A flit is granted only if its stamp minus the request-cycle time is at most WINDOW. Otherwise its grant is 0 and the output's bookkeeping is unchanged by it.
- R8: While an output receives no grants, its backlog shrinks by one slot per cycle, down to zero.
- R9: Each output's bookkeeping is independent of requests to the other outputs.
- R10: A port whose req_valid is low, or whose destination field (bits DW*i+DW-1..DW*i of req_dest, with DW = clog2(PORTS)) is not below PORTS, gets no grant. It also does not change any output's bookkeeping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | PORTS | A flit is presented on port i |
| req_retry | input | PORTS | The flit on port i is returning after a downstream failure |
| req_dest | input | PORTS*DW | Requested output index per port |
| gnt | output | PORTS | Port i was given a timestamp (one cycle after request) |
| ts | output | PORTS*TS_W | Timestamp for port i, valid when its grant is high |
| now_time | output | TS_W | Free-running time counter |

## Verification
The bench builds the block with five ports and an 8-bit time counter, the same as the defaults. It narrows WINDOW to 8, so that one output fed by all five ports runs into the booking limit within two cycles and denials can be observed. A run of several hundred cycles with mixed traffic carries the counter and the stamps through the wrap from 255 to 0. It also exercises retry ordering, backlog drain after idle cycles, and invalid destinations.

// File: rtl/tstamp_pkg.sv
// Package: shared defaults and helper types for the flit timestamper.
// Assumes nothing; holds constants only.
package tstamp_pkg;
    localparam int DEF_PORTS  = 5;
    localparam int DEF_TS_W   = 8;
    localparam int DEF_WINDOW = 64;
endpackage

// File: rtl/ts_time_base.sv
// Module: free-running departure-time counter.
// Counts one per cycle and wraps modulo 2^TS_W. Assumes a continuous clock.
module ts_time_base #(
    parameter int TS_W = tstamp_pkg::DEF_TS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] now
);
    // Advance the time counter every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + TS_W'(1);
    end

    // R2
    time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> now == $past(now) + TS_W'(1));
endmodule

// File: rtl/ts_out_slot.sv
// Module: bookkeeping for one output.
// Holds the backlog (last assigned slot minus current time, floored at 0).
// Stamps this cycle's retries first, then new flits, each in ascending port
// order. Denies any flit whose slot would lie beyond WINDOW.
// Assumes retry_mask and new_mask are disjoint and WINDOW+PORTS < 2^TS_W.
module ts_out_slot #(
    parameter int PORTS  = tstamp_pkg::DEF_PORTS,
    parameter int TS_W   = tstamp_pkg::DEF_TS_W,
    parameter int WINDOW = tstamp_pkg::DEF_WINDOW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TS_W-1:0]       now,
    input  logic [PORTS-1:0]      retry_mask,
    input  logic [PORTS-1:0]      new_mask,
    output logic [PORTS-1:0]      slot_gnt,
    output logic [PORTS*TS_W-1:0] slot_ts
);
    localparam logic [TS_W-1:0] WIN_V = TS_W'(WINDOW);

    logic [TS_W-1:0] backlog;
    logic [TS_W-1:0] rank [PORTS];
    logic [TS_W-1:0] n_gnt;
    logic [TS_W-1:0] backlog_nxt;

    // Rank requests: retries in port order, then new flits in port order.
    always_comb begin
        logic [TS_W-1:0] cnt;
        cnt = '0;
        for (int i = 0; i < PORTS; i++) begin
            rank[i] = '0;
            if (retry_mask[i]) begin
                rank[i] = cnt;
                cnt = cnt + TS_W'(1);
            end
        end
        for (int i = 0; i < PORTS; i++) begin
            if (new_mask[i]) begin
                rank[i] = cnt;
                cnt = cnt + TS_W'(1);
            end
        end
    end

    // Grant within the window and form each stamp.
    always_comb begin
        n_gnt   = '0;
        slot_ts = '0;
        for (int i = 0; i < PORTS; i++) begin
            slot_gnt[i] = (retry_mask[i] | new_mask[i]) && (backlog + rank[i] < WIN_V);
            if (slot_gnt[i]) begin
                n_gnt = n_gnt + TS_W'(1);
                slot_ts[i*TS_W +: TS_W] = now + TS_W'(1) + backlog + rank[i];
            end
        end
        backlog_nxt = (backlog + n_gnt == '0) ? '0 : backlog + n_gnt - TS_W'(1);
    end

    // Update the backlog as time moves one slot forward.
    always_ff @(posedge clk) begin
        if (!rst_n) backlog <= '0;
        else        backlog <= backlog_nxt;
    end

    // R7
    backlog_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        backlog <= WIN_V);

    // R8
    backlog_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (backlog != '0 && slot_gnt == '0) |=> backlog == $past(backlog) - TS_W'(1));
endmodule

// File: rtl/flit_timestamper.sv
// Module: top of the timestamper.
// Decodes each port's destination, hands the requests to one bookkeeping slot
// per output, merges the per-port results and registers them.
// Assumes each port names at most one output per cycle.
module flit_timestamper #(
    parameter int PORTS  = tstamp_pkg::DEF_PORTS,
    parameter int TS_W   = tstamp_pkg::DEF_TS_W,
    parameter int WINDOW = tstamp_pkg::DEF_WINDOW,
    localparam int DW    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PORTS-1:0]      req_valid,
    input  logic [PORTS-1:0]      req_retry,
    input  logic [PORTS*DW-1:0]   req_dest,
    output logic [PORTS-1:0]      gnt,
    output logic [PORTS*TS_W-1:0] ts,
    output logic [TS_W-1:0]       now_time
);
    logic [PORTS-1:0]      hit_new   [PORTS];
    logic [PORTS-1:0]      hit_retry [PORTS];
    logic [PORTS-1:0]      s_gnt     [PORTS];
    logic [PORTS*TS_W-1:0] s_ts      [PORTS];
    logic [PORTS-1:0]      gnt_c;
    logic [PORTS*TS_W-1:0] ts_c;

    ts_time_base #(.TS_W(TS_W)) u_time (
        .clk(clk), .rst_n(rst_n), .now(now_time)
    );

    // Split requests by destination and by retry flag.
    always_comb begin
        for (int o = 0; o < PORTS; o++) begin
            for (int i = 0; i < PORTS; i++) begin
                hit_new[o][i]   = req_valid[i] && !req_retry[i] && (req_dest[i*DW +: DW] == DW'(o));
                hit_retry[o][i] = req_valid[i] &&  req_retry[i] && (req_dest[i*DW +: DW] == DW'(o));
            end
        end
    end

    for (genvar o = 0; o < PORTS; o++) begin : g_out
        ts_out_slot #(.PORTS(PORTS), .TS_W(TS_W), .WINDOW(WINDOW)) u_slot (
            .clk(clk), .rst_n(rst_n), .now(now_time),
            .retry_mask(hit_retry[o]), .new_mask(hit_new[o]),
            .slot_gnt(s_gnt[o]), .slot_ts(s_ts[o])
        );
    end

    // Merge the per-output answers back to per-port results.
    always_comb begin
        gnt_c = '0;
        ts_c  = '0;
        for (int o = 0; o < PORTS; o++) begin
            for (int i = 0; i < PORTS; i++) begin
                if (s_gnt[o][i]) begin
                    gnt_c[i] = 1'b1;
                    ts_c[i*TS_W +: TS_W] = s_ts[o][i*TS_W +: TS_W];
                end
            end
        end
    end

    // Register the grants and stamps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt <= '0;
            ts  <= '0;
        end else begin
            gnt <= gnt_c;
            ts  <= ts_c;
        end
    end

    for (genvar i = 0; i < PORTS; i++) begin : g_chk
        // R10
        gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[i] |-> $past(req_valid[i]));
        // R7
        stamp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[i] |-> (ts[i*TS_W +: TS_W] - now_time) < TS_W'(WINDOW));
    end
endmodule

// File: tb/sim_flit_timestamper.sv
module sim_flit_timestamper;
    localparam int P = 5;
    localparam int TW = 8;
    localparam int W = 8;
    localparam int DW = 3;

    logic clk = 0;
    logic rst_n = 0;
    logic [P-1:0] req_valid = '0;
    logic [P-1:0] req_retry = '0;
    logic [P*DW-1:0] req_dest = '0;
    logic [P-1:0] gnt;
    logic [P*TW-1:0] ts;
    logic [TW-1:0] now_time;

    int tests = 0;
    int fails = 0;

    typedef struct {
        int port;
        bit g;
        bit [TW-1:0] t;
        bit [TW-1:0] nw;
        string tag;
    } item_t;
    item_t q[$];

    int now_m = 0;
    int pend_m [P];

    flit_timestamper #(.PORTS(P), .TS_W(TW), .WINDOW(W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_retry(req_retry),
        .req_dest(req_dest), .gnt(gnt), .ts(ts), .now_time(now_time)
    );

    always #10 clk = ~clk;

    // Driver: apply one cycle of requests and push the expected results.
    task automatic cycle(input logic [P-1:0] v, input logic [P-1:0] r,
                         input logic [P*DW-1:0] d, input string tag);
        bit eg [P];
        int et [P];
        req_valid = v; req_retry = r; req_dest = d;
        for (int i = 0; i < P; i++) begin eg[i] = 0; et[i] = 0; end
        for (int o = 0; o < P; o++) begin
            int rk = 0;
            int n = 0;
            for (int pass = 0; pass < 2; pass++) begin
                for (int i = 0; i < P; i++) begin
                    if (v[i] && (r[i] == (pass == 0)) && int'(d[i*DW +: DW]) == o) begin
                        if (pend_m[o] + rk < W) begin
                            eg[i] = 1;
                            et[i] = (now_m + 1 + pend_m[o] + rk) % 256;
                            n++;
                        end
                        rk++;
                    end
                end
            end
            pend_m[o] = (pend_m[o] + n - 1 < 0) ? 0 : pend_m[o] + n - 1;
        end
        for (int i = 0; i < P; i++) begin
            item_t it;
            it.port = i; it.g = eg[i]; it.t = TW'(et[i]);
            it.nw = TW'((now_m + 1) % 256); it.tag = tag;
            q.push_back(it);
        end
        now_m = (now_m + 1) % 256;
        @(negedge clk);
    endtask

    // Monitor: compare results one cycle after each request.
    always @(posedge clk) begin
        #2;
        if (q.size() >= P) begin
            for (int k = 0; k < P; k++) begin
                item_t it;
                it = q.pop_front();
                tests++;
                if (gnt[it.port] !== it.g || (it.g && ts[it.port*TW +: TW] !== it.t)
                    || now_time !== it.nw) begin
                    fails++;
                    $display("FAIL %s port %0d: gnt=%0b ts=%0d now=%0d expected gnt=%0b ts=%0d now=%0d",
                             it.tag, it.port, gnt[it.port], ts[it.port*TW +: TW], now_time,
                             it.g, it.t, it.nw);
                end
            end
        end
    end

    function automatic logic [P*DW-1:0] dests(input int a, input int b, input int c,
                                              input int e, input int f);
        return {DW'(f), DW'(e), DW'(c), DW'(b), DW'(a)};
    endfunction

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int o = 0; o < P; o++) pend_m[o] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        tests++;
        if (gnt !== '0 || now_time !== '0) begin
            fails++;
            $display("FAIL R1: gnt=%0h now=%0d expected gnt=0 now=0", gnt, now_time);
        end
        rst_n = 1;
        now_m = 0;
        // R3: lone flit to an idle output
        cycle(5'b00001, 5'b0, dests(2,0,0,0,0), "R3");
        // R5: three new flits to output 3 in one cycle
        cycle(5'b10110, 5'b0, dests(0,3,3,0,3), "R5");
        // R4: next flit to output 3 continues after the last stamp
        cycle(5'b00001, 5'b0, dests(3,0,0,0,0), "R4");
        // R6: retry on port 3 goes ahead of new flits on ports 0 and 4
        cycle(5'b11001, 5'b01000, dests(1,0,0,1,1), "R6");
        // R9: all five outputs at once, one flit each
        cycle(5'b11111, 5'b0, dests(4,3,2,1,0), "R9");
        // R8: idle cycles drain backlog, then new stamps restart at now+1
        cycle(5'b0, 5'b0, '0, "R8");
        cycle(5'b0, 5'b0, '0, "R8");
        cycle(5'b00110, 5'b0, dests(0,1,3,0,0), "R8");
        // R7: saturate output 4 until the window denies flits
        cycle(5'b11111, 5'b0, dests(4,4,4,4,4), "R7");
        cycle(5'b11111, 5'b0, dests(4,4,4,4,4), "R7");
        cycle(5'b11111, 5'b00100, dests(4,4,4,4,4), "R7");
        // R10: unrequested and out-of-range destinations do nothing
        cycle(5'b00000, 5'b11111, dests(0,0,0,0,0), "R10");
        cycle(5'b00011, 5'b0, dests(5,7,0,0,0), "R10");
        cycle(5'b00001, 5'b0, dests(0,0,0,0,0), "R10");
        // R2: long mixed run through counter wraparound
        for (int k = 0; k < 320; k++) begin
            logic [P-1:0] v;
            logic [P-1:0] r;
            v = P'((k * 7 + 3) % 32) & ((k % 4 == 3) ? 5'b0 : 5'b11111);
            r = P'((k * 5) % 32) & 5'b01010;
            cycle(v, r, dests(k % 5, (k / 3) % 5, 2, (k * 2) % 5, (k / 7) % 5), "R2");
        end
        cycle(5'b0, 5'b0, '0, "R2");
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule